// File: doc/BRIEF.md
# SPI Subordinate Packet Mailbox

This block is the subordinate end of a byte-oriented SPI link. It runs on the system clock and oversamples the serial clock, the active-low chip select and the serial data input. A frame opens with a command byte, followed by a 16-bit address and then data bytes. The command byte carries a chip identity, a multichip slot and an opcode. Only frames whose identity and slot match the block's parameters are answered. All other frames leave the serial output undriven and change nothing.

Over SPI the master reaches four regions:
- an inbound packet buffer, which it can read and write;
- an outbound packet buffer, which it can only read;
- a 32-bit status word;
- a 32-bit acknowledge word.

The local processor reads the inbound buffer and fills the outbound buffer through a plain port of its own. It rings a doorbell that raises an interrupt toward the master. The master answers by writing the acknowledge word. That write drops the interrupt and sends a one-cycle packet-received strobe back to the local side.

Top module: `spi_mbx_sub`

## Requirements
- R1: A frame is served only when command bits [7:4] equal CHIP_ID and bits [3:2] equal MCHIP_ID (command byte is the first byte after cs_ni falls, MSB first). A frame that does not match leaves miso_oe_o low and writes nothing.
- R2: Command bits [1:0] select the operation: 00 is read and 01 is write. The codes 10 and 11 are reserved. A reserved frame is ignored until cs_ni goes high, and the next frame decodes normally.
- R3: The address is 16 bits, high byte first. All bytes are MSB first. mosi_i is sampled on rising sclk_i edges and miso_o changes on falling edges. miso_oe_o is high only in the data phase of a matching read frame.
- R4: Addresses 0xA000 to 0xA000+BUF_BYTES-1 map the inbound buffer. The byte at offset n is written and read over SPI, and the local side reads it at lcl_ib_addr_i = n.
- R5: Addresses 0xB000 to 0xB000+BUF_BYTES-1 map the outbound buffer. It is written only by the local port and is read over SPI. An SPI write to it is discarded and sets a sticky write-protect error.
- R6: After each data byte the address advances by one. Inside a buffer it stops at the buffer's last byte, so later bytes reuse that byte.
- R7: The status word sits at 0x9004 to 0x9007, most significant byte first. Bit 0 is the interrupt-pending flag, bit 1 is the write-protect error, and all other bits are zero.
- R8: A local doorbell write whose value is exactly 0x00000001 raises irq_o on the next cycle. Other values have no effect. If a doorbell write and an acknowledge arrive in the same cycle, the doorbell wins.
- R9: When the master writes the final byte at 0x9107 of the acknowledge word (0x9104 to 0x9107, MSB first), three things happen: irq_o clears, the write-protect error clears, and pkt_ack_o pulses for one cycle. Reading 0x9104 returns the word last written.
- R10: Reads of unmapped addresses return zero bytes with miso_oe_o high. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x sclk_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Pad enable for miso_o; low means high-impedance |
| lcl_ib_addr_i | input | AW | Local read address into inbound buffer |
| lcl_ib_rdata_o | output | 8 | Inbound buffer byte at lcl_ib_addr_i |
| lcl_ob_we_i | input | 1 | Local write strobe for outbound buffer |
| lcl_ob_addr_i | input | AW | Local write address into outbound buffer |
| lcl_ob_wdata_i | input | 8 | Local write data |
| db_we_i | input | 1 | Doorbell write strobe |
| db_wdata_i | input | 32 | Doorbell write value |
| irq_o | output | 1 | Interrupt toward the master |
| pkt_ack_o | output | 1 | One-cycle packet-received strobe to the local side |

## Verification
The checker module watches several rules on every cycle:
- miso_oe_o drops within one cycle of chip select going inactive;
- a doorbell of value one raises the interrupt, and the interrupt rises only after such a doorbell;
- the interrupt and the write-protect error fall only together with a single-cycle acknowledge strobe.

Other behaviour spans whole frames and only the bench scenarios can show it. This covers identity and opcode filtering, the write protection of the outbound buffer, the stop at the end of a buffer, the byte order of the status and acknowledge words, and the zero bytes returned for unmapped addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {PH_CMD, PH_AHI, PH_ALO, PH_DATA, PH_SKIP} phase_e;

  localparam logic [15:0] IB_BASE  = 16'hA000;
  localparam logic [15:0] OB_BASE  = 16'hB000;
  localparam logic [15:0] ST_ADDR  = 16'h9004;
  localparam logic [15:0] ACK_ADDR = 16'h9104;

  // big-endian byte select within a 32-bit word
  function automatic logic [7:0] word_byte(logic [31:0] w, logic [1:0] sel);
    case (sel)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/mbx_shift.sv
module mbx_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic       sclk_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic       rise, fall;

  assign rise = sclk_i & ~sclk_q;
  assign fall = ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      miso_o     <= 1'b0;
    end else begin
      sclk_q     <= sclk_i;
      rx_valid_o <= 1'b0;
      if (!active_i) begin
        bit_cnt <= '0;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_valid_o <= 1'b1;
            rx_byte_o  <= {rx_sr, mosi_i};
          end
        end
        if (fall) begin
          // byte boundary: load the next byte, else keep shifting
          if (bit_cnt == 3'd0) begin
            miso_o <= tx_byte_i[7];
            tx_sr  <= {tx_byte_i[6:0], 1'b0};
          end else begin
            miso_o <= tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mbx_ctl.sv
module mbx_ctl
  import mbx_pkg::*;
#(
  parameter logic [3:0]  CHIP_ID   = 4'h1,
  parameter logic [1:0]  MCHIP_ID  = 2'd0,
  parameter int unsigned BUF_BYTES = 256,
  localparam int unsigned AW = $clog2(BUF_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  output logic [7:0]    tx_byte_o,
  output logic          miso_oe_o,
  input  logic [AW-1:0] lcl_ib_addr_i,
  output logic [7:0]    lcl_ib_rdata_o,
  input  logic          lcl_ob_we_i,
  input  logic [AW-1:0] lcl_ob_addr_i,
  input  logic [7:0]    lcl_ob_wdata_i,
  input  logic          db_we_i,
  input  logic [31:0]   db_wdata_i,
  output logic          irq_o,
  output logic          pkt_ack_o,
  output logic          wp_err_o
);
  localparam logic [15:0] LAST = 16'(BUF_BYTES - 1);

  logic [7:0]  ib_mem [BUF_BYTES];
  logic [7:0]  ob_mem [BUF_BYTES];
  phase_e      phase;
  logic        wr_q;
  logic [7:0]  ahi_q;
  logic [15:0] ptr, ptr_nxt, ib_off, ob_off;
  logic [31:0] ack_q;
  logic        in_ib, in_ob, in_st, in_ack;
  logic        wr_hit, ack_fire, cmd_ok;

  assign ib_off = ptr - IB_BASE;
  assign ob_off = ptr - OB_BASE;
  assign in_ib  = ib_off <= LAST;
  assign in_ob  = ob_off <= LAST;
  assign in_st  = ptr[15:2] == ST_ADDR[15:2];
  assign in_ack = ptr[15:2] == ACK_ADDR[15:2];

  assign cmd_ok   = rx_byte_i[7:4] == CHIP_ID && rx_byte_i[3:2] == MCHIP_ID && !rx_byte_i[1];
  assign wr_hit   = active_i && rx_valid_i && phase == PH_DATA && wr_q;
  assign ack_fire = wr_hit && in_ack && ptr[1:0] == 2'd3;

  // stop at the last byte of a buffer
  assign ptr_nxt = ((in_ib && ib_off == LAST) || (in_ob && ob_off == LAST)) ? ptr : ptr + 16'd1;

  always_comb begin
    if (in_ib)       tx_byte_o = ib_mem[ib_off[AW-1:0]];
    else if (in_ob)  tx_byte_o = ob_mem[ob_off[AW-1:0]];
    else if (in_st)  tx_byte_o = word_byte({30'd0, wp_err_o, irq_o}, ptr[1:0]);
    else if (in_ack) tx_byte_o = word_byte(ack_q, ptr[1:0]);
    else             tx_byte_o = 8'h00;
  end

  assign lcl_ib_rdata_o = ib_mem[lcl_ib_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase     <= PH_CMD;
      wr_q      <= 1'b0;
      ahi_q     <= '0;
      ptr       <= '0;
      miso_oe_o <= 1'b0;
    end else if (!active_i) begin
      phase     <= PH_CMD;
      miso_oe_o <= 1'b0;
    end else if (rx_valid_i) begin
      case (phase)
        PH_CMD: begin
          wr_q  <= rx_byte_i[0];
          phase <= cmd_ok ? PH_AHI : PH_SKIP;
        end
        PH_AHI: begin
          ahi_q <= rx_byte_i;
          phase <= PH_ALO;
        end
        PH_ALO: begin
          ptr       <= {ahi_q, rx_byte_i};
          phase     <= PH_DATA;
          miso_oe_o <= !wr_q;
        end
        PH_DATA: ptr <= ptr_nxt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      wp_err_o  <= 1'b0;
      pkt_ack_o <= 1'b0;
      ack_q     <= '0;
    end else begin
      pkt_ack_o <= ack_fire;
      if (db_we_i && db_wdata_i == 32'd1) irq_o <= 1'b1;
      else if (ack_fire)                  irq_o <= 1'b0;
      if (ack_fire)                 wp_err_o <= 1'b0;
      else if (wr_hit && in_ob)     wp_err_o <= 1'b1;
      if (wr_hit && in_ack) begin
        case (ptr[1:0])
          2'd0:    ack_q[31:24] <= rx_byte_i;
          2'd1:    ack_q[23:16] <= rx_byte_i;
          2'd2:    ack_q[15:8]  <= rx_byte_i;
          default: ack_q[7:0]   <= rx_byte_i;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_hit && in_ib) ib_mem[ib_off[AW-1:0]] <= rx_byte_i;
  end

  always_ff @(posedge clk_i) begin
    if (lcl_ob_we_i) ob_mem[lcl_ob_addr_i] <= lcl_ob_wdata_i;
  end
endmodule

// File: rtl/spi_mbx_sub.sv
module spi_mbx_sub #(
  parameter logic [3:0]  CHIP_ID   = 4'h1,
  parameter logic [1:0]  MCHIP_ID  = 2'd0,
  parameter int unsigned BUF_BYTES = 256,
  localparam int unsigned AW = $clog2(BUF_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic [AW-1:0] lcl_ib_addr_i,
  output logic [7:0]    lcl_ib_rdata_o,
  input  logic          lcl_ob_we_i,
  input  logic [AW-1:0] lcl_ob_addr_i,
  input  logic [7:0]    lcl_ob_wdata_i,
  input  logic          db_we_i,
  input  logic [31:0]   db_wdata_i,
  output logic          irq_o,
  output logic          pkt_ack_o
);
  logic       sclk_s, cs_n_s, mosi_s, cs_act;
  logic       rx_valid, wp_err;
  logic [7:0] rx_byte, tx_byte;

  mbx_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   ({sclk_s, cs_n_s, mosi_s})
  );

  assign cs_act = ~cs_n_s;

  mbx_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (cs_act),
    .sclk_i    (sclk_s),
    .mosi_i    (mosi_s),
    .tx_byte_i (tx_byte),
    .rx_valid_o(rx_valid),
    .rx_byte_o (rx_byte),
    .miso_o    (miso_o)
  );

  mbx_ctl #(.CHIP_ID(CHIP_ID), .MCHIP_ID(MCHIP_ID), .BUF_BYTES(BUF_BYTES)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .active_i      (cs_act),
    .rx_valid_i    (rx_valid),
    .rx_byte_i     (rx_byte),
    .tx_byte_o     (tx_byte),
    .miso_oe_o     (miso_oe_o),
    .lcl_ib_addr_i (lcl_ib_addr_i),
    .lcl_ib_rdata_o(lcl_ib_rdata_o),
    .lcl_ob_we_i   (lcl_ob_we_i),
    .lcl_ob_addr_i (lcl_ob_addr_i),
    .lcl_ob_wdata_i(lcl_ob_wdata_i),
    .db_we_i       (db_we_i),
    .db_wdata_i    (db_wdata_i),
    .irq_o         (irq_o),
    .pkt_ack_o     (pkt_ack_o),
    .wp_err_o      (wp_err)
  );
endmodule

// File: rtl/spi_mbx_sub_chk.sv
module spi_mbx_sub_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_act_i,
  input logic        miso_oe_i,
  input logic        db_we_i,
  input logic [31:0] db_wdata_i,
  input logic        irq_i,
  input logic        pkt_ack_i,
  input logic        wp_err_i
);
  p_oe_needs_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_oe_i);

  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_we_i && db_wdata_i == 32'd1) |=> irq_i);

  p_irq_rise_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(db_we_i && db_wdata_i == 32'd1));

  p_irq_fall_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_i) |-> pkt_ack_i);

  p_ack_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_ack_i |=> !pkt_ack_i);

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wp_err_i) |-> pkt_ack_i);
endmodule

bind spi_mbx_sub spi_mbx_sub_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_act_i  (cs_act),
  .miso_oe_i (miso_oe_o),
  .db_we_i   (db_we_i),
  .db_wdata_i(db_wdata_i),
  .irq_i     (irq_o),
  .pkt_ack_i (pkt_ack_o),
  .wp_err_i  (wp_err)
);

// File: tb/tb_spi_mbx_sub.sv
module tb_spi_mbx_sub;
  localparam int BUF  = 256;
  localparam int AW   = $clog2(BUF);
  localparam int HALF = 8;
  localparam logic [7:0] RD = 8'h10, WR = 8'h11;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic          miso_o, miso_oe_o, irq_o, pkt_ack_o;
  logic [AW-1:0] lcl_ib_addr = '0, lcl_ob_addr = '0;
  logic [7:0]    lcl_ib_rdata, lcl_ob_wdata = '0;
  logic          lcl_ob_we = 1'b0, db_we = 1'b0;
  logic [31:0]   db_wdata = '0;

  int n_chk = 0, n_fail = 0, ack_cnt = 0;
  bit done = 0, oe_seen;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];
  logic [7:0] exp_buf [16];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  spi_mbx_sub dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .lcl_ib_addr_i(lcl_ib_addr), .lcl_ib_rdata_o(lcl_ib_rdata),
    .lcl_ob_we_i(lcl_ob_we), .lcl_ob_addr_i(lcl_ob_addr), .lcl_ob_wdata_i(lcl_ob_wdata),
    .db_we_i(db_we), .db_wdata_i(db_wdata), .irq_o(irq_o), .pkt_ack_o(pkt_ack_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (pkt_ack_o) ack_cnt++;

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g === e, t, 32'(g), 32'(e));
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso_o;
      if (miso_oe_o) oe_seen = 1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_frame(input logic [7:0] cmd, input logic [15:0] addr, input int n);
    logic [7:0] r;
    oe_seen = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte(cmd, r);
    spi_byte(addr[15:8], r);
    spi_byte(addr[7:0], r);
    for (int i = 0; i < n; i++) begin
      spi_byte(tx_buf[i], r);
      rx_buf[i] = r;
    end
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic spi_write4(input logic [7:0] cmd, input logic [15:0] addr, input logic [31:0] w);
    tx_buf[0] = w[31:24]; tx_buf[1] = w[23:16]; tx_buf[2] = w[15:8]; tx_buf[3] = w[7:0];
    spi_frame(cmd, addr, 4);
  endtask

  // driver: queue expected bytes, run the read, hand results to the monitor
  task automatic sb_read(input logic [15:0] addr, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_buf[i]);
      tag_q.push_back(tag);
      tx_buf[i] = 8'h00;
    end
    spi_frame(RD, addr, n);
    for (int i = 0; i < n; i++) got_q.push_back(rx_buf[i]);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_exp4(input logic [31:0] w);
    exp_buf[0] = w[31:24]; exp_buf[1] = w[23:16]; exp_buf[2] = w[15:8]; exp_buf[3] = w[7:0];
  endtask

  task automatic lcl_ib_chk(input int a, input logic [7:0] e, input string tag);
    lcl_ib_addr = AW'(a);
    #1;
    chk(lcl_ib_rdata === e, tag, 32'(lcl_ib_rdata), 32'(e));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq_o === 1'b0, "R8 irq after reset", 32'(irq_o), 0);
    chk(pkt_ack_o === 1'b0, "R9 ack after reset", 32'(pkt_ack_o), 0);
    chk(miso_oe_o === 1'b0, "R3 oe after reset", 32'(miso_oe_o), 0);

    // R4: SPI write to inbound, local read
    spi_write4(WR, 16'hA000, 32'h11223344);
    lcl_ib_chk(0, 8'h11, "R4 ib[0]");
    lcl_ib_chk(1, 8'h22, "R4 ib[1]");
    lcl_ib_chk(3, 8'h44, "R4 ib[3]");
    set_exp4(32'h11223344);
    sb_read(16'hA000, 4, "R4 spi read inbound");
    chk(oe_seen, "R3 oe in read data phase", 32'(oe_seen), 1);

    // R5: local fills outbound, SPI reads it
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lcl_ob_we = 1'b1; lcl_ob_addr = AW'(i); lcl_ob_wdata = 8'hA1 + 8'(i * 17);
    end
    @(negedge clk);
    lcl_ob_we = 1'b0;
    set_exp4(32'hA1B2C3D4);
    sb_read(16'hB000, 4, "R5 spi read outbound");

    // R5: SPI write to outbound is discarded and flags error; R7 status layout
    tx_buf[0] = 8'h5A;
    spi_frame(WR, 16'hB001, 1);
    set_exp4(32'hA1B2C3D4);
    sb_read(16'hB000, 4, "R5 outbound write-protected");
    set_exp4(32'h00000002);
    sb_read(16'h9004, 4, "R7 status err bit1");

    // R8: doorbell
    @(negedge clk); db_we = 1'b1; db_wdata = 32'd2;
    @(negedge clk); db_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq_o === 1'b0, "R8 doorbell value 2 ignored", 32'(irq_o), 0);
    db_we = 1'b1; db_wdata = 32'd1;
    @(negedge clk); db_we = 1'b0;
    chk(irq_o === 1'b1, "R8 doorbell raises irq", 32'(irq_o), 1);
    set_exp4(32'h00000003);
    sb_read(16'h9004, 4, "R7 status irq+err");

    // R9: acknowledge
    ack_cnt = 0;
    spi_write4(WR, 16'h9104, 32'hDEADBEEF);
    chk(ack_cnt == 1, "R9 single ack pulse", 32'(ack_cnt), 1);
    chk(irq_o === 1'b0, "R9 irq cleared", 32'(irq_o), 0);
    set_exp4(32'h00000000);
    sb_read(16'h9004, 4, "R9 status cleared");
    set_exp4(32'hDEADBEEF);
    sb_read(16'h9104, 4, "R9 ack word readback");

    // R1: identity mismatch
    tx_buf[0] = 8'h00;
    spi_frame(8'h20, 16'hA000, 1);
    chk(!oe_seen, "R1 wrong chip id no drive", 32'(oe_seen), 0);
    tx_buf[0] = 8'hFF;
    spi_frame(8'h21, 16'hA000, 1);
    lcl_ib_chk(0, 8'h11, "R1 wrong chip id no write");
    spi_frame(8'h15, 16'hA000, 1);
    lcl_ib_chk(0, 8'h11, "R1 wrong slot no write");

    // R2: reserved opcode ignored; next frame decodes
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'hFF;
    spi_frame(8'h12, 16'hA000, 2);
    lcl_ib_chk(0, 8'h11, "R2 reserved op no write");
    lcl_ib_chk(1, 8'h22, "R2 reserved op no write b1");
    set_exp4(32'h11223344);
    sb_read(16'hA000, 4, "R2 frame after reserved");

    // R6: stop at end of buffer
    tx_buf[0] = 8'h61; tx_buf[1] = 8'h62; tx_buf[2] = 8'h63;
    spi_frame(WR, 16'hA000 + 16'(BUF - 2), 3);
    lcl_ib_chk(BUF - 2, 8'h61, "R6 ib[last-1]");
    lcl_ib_chk(BUF - 1, 8'h63, "R6 ib[last] holds final");
    exp_buf[0] = 8'h63; exp_buf[1] = 8'h63;
    sb_read(16'hA000 + 16'(BUF - 1), 2, "R6 read sticks at last");

    // R10: unmapped
    exp_buf[0] = 8'h00; exp_buf[1] = 8'h00;
    sb_read(16'h1234, 2, "R10 unmapped reads zero");
    chk(oe_seen, "R10 unmapped read drives", 32'(oe_seen), 1);

    repeat (10) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule